// File: doc/BRIEF.md
# Posted Write Acceptance Controller

This block is the target-side decision logic of a bridge port that takes in posted memory writes. For each data phase the initiator presents, it chooses one of three answers. It can accept the data and keep the burst going. It can accept the data and disconnect on that phase. Or it can refuse the phase (retry or disconnect without data). When data is accepted, the block strobes a write into the posted write buffer and gives the DWORD address for that write.

The stop point of a burst depends on several things: the command (plain memory write or memory write and invalidate), the programmed cache line size, a line-disconnect enable bit from configuration, the page boundary, and the number of free DWORD slots in the buffer. A burst is opened by a start pulse that comes with its first data phase. Response outputs are active high. They are driven combinationally from the current phase, and a registered address tracks the burst.

Top module: `pw_accept_ctl`

## Requirements
- R1: While a transaction is open and at least one free slot is reported, every valid data phase asserts devsel, trdy and the write strobe, and the write address steps by one DWORD per accepted phase, starting at the start address.
- R2: A phase accepted with exactly one free slot, and which is not the initiator's last, also asserts stop, so the burst is disconnected with that data taken.
- R3: For memory write and invalidate (mwi_i=1), when the cache line size is 1, 2, 4, 8 or 16 DWORDs, stop is asserted on the accepted phase whose incremented address is a multiple of the line size.
- R4: For a plain memory write with the line-disconnect enable set, the same cache line stop as in R3 applies.
- R5: For a plain memory write with the line-disconnect enable clear, the cache line boundary has no effect.
- R6: A cache line size of 0 or any value that is not 1, 2, 4, 8 or 16 causes no cache line stop for either command.
- R7: Stop is always asserted on an accepted non-last phase whose incremented address is aligned to the page size (PAGE_BYTES/4 DWORDs).
- R8: A first data phase arriving with zero free slots is answered with devsel and stop, without trdy and without a write strobe (retry).
- R9: A new transaction may start in the cycle right after the previous one ends. It is accepted if space exists and retried if not.
- R10: A phase marked last never asserts stop while space exists. After any phase with stop or last, devsel is low in the next cycle unless a new start arrives. After reset, all response outputs are low.
- R11: A non-first phase arriving with zero free slots asserts stop without trdy or a write strobe, which ends the burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | First data phase of a new transaction |
| valid_i | input | 1 | Initiator presents a data phase |
| last_i | input | 1 | This phase is the initiator's final one |
| mwi_i | input | 1 | Command at start: 1 memory write and invalidate, 0 memory write |
| addr_i | input | ADDR_W | DWORD start address, sampled with start_i |
| cls_i | input | 8 | Cache line size in DWORDs |
| line_disc_en_i | input | 1 | Enables cache line stops for plain memory writes |
| free_i | input | FREE_W | Free DWORD slots in the posted write buffer |
| devsel_o | output | 1 | Target claims the transaction |
| trdy_o | output | 1 | Data of this phase is taken |
| stop_o | output | 1 | Target ends the burst on this phase |
| wr_o | output | 1 | Buffer write strobe |
| wr_addr_o | output | ADDR_W | DWORD address of the current phase |

## Verification
The bench builds the block with ADDR_W=16, FREE_W=6 and PAGE_BYTES=256. With these values a page is only 64 DWORDs, so page stops can be reached within short bursts near addresses 0x40 and 0x80. At the same time, cache line stops of 4 and 8 DWORDs stay clearly separate from page stops. Because the free count is only six bits wide, buffer-fill disconnects and zero-space retries can be driven directly with small values.

// File: rtl/pw_accept_ctl.sv
module pw_accept_ctl #(
  parameter int ADDR_W     = 30,
  parameter int FREE_W     = 8,
  parameter int PAGE_BYTES = 4096
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              valid_i,
  input  logic              last_i,
  input  logic              mwi_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        cls_i,
  input  logic              line_disc_en_i,
  input  logic [FREE_W-1:0] free_i,
  output logic              devsel_o,
  output logic              trdy_o,
  output logic              stop_o,
  output logic              wr_o,
  output logic [ADDR_W-1:0] wr_addr_o
);
  localparam int PAGE_LSB = $clog2(PAGE_BYTES / 4);

  logic              active_q, mwi_q;
  logic [ADDR_W-1:0] addr_q;

  logic              in_txn, mwi, cls_ok, line_hit, page_hit;
  logic              phase, room, fills, take, done;
  logic [ADDR_W-1:0] cur, nxt, line_mask;

  assign in_txn    = start_i | active_q;
  assign mwi       = start_i ? mwi_i : mwi_q;
  assign cur       = start_i ? addr_i : addr_q;
  assign nxt       = cur + 1'b1;
  assign cls_ok    = (cls_i == 8'd1) || (cls_i == 8'd2) || (cls_i == 8'd4) ||
                     (cls_i == 8'd8) || (cls_i == 8'd16);
  assign line_mask = ADDR_W'(cls_i) - 1'b1;
  assign line_hit  = cls_ok && (mwi || line_disc_en_i) && ((nxt & line_mask) == '0);
  assign page_hit  = (nxt[PAGE_LSB-1:0] == '0);

  assign phase = in_txn & valid_i;
  assign room  = (free_i != '0);
  assign fills = (free_i == FREE_W'(1));
  assign take  = phase & room;
  assign done  = phase & (stop_o | last_i);

  assign devsel_o  = in_txn;
  assign trdy_o    = take;
  assign wr_o      = take;
  assign stop_o    = phase & (~room | (~last_i & (fills | line_hit | page_hit)));
  assign wr_addr_o = cur;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      mwi_q    <= 1'b0;
      addr_q   <= '0;
    end else begin
      active_q <= in_txn & ~done;
      if (start_i) mwi_q <= mwi_i;
      if (take) addr_q <= nxt;
      else if (start_i) addr_q <= addr_i;
    end
  end

  assert_addr_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_o && !stop_o && !last_i) |=> (!valid_i || start_i ||
      wr_addr_o == ADDR_W'($past(wr_addr_o) + 1'b1)));

  assert_fill_disc_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_o && free_i == FREE_W'(1) && !last_i) |-> stop_o);

  assert_page_disc_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_o && !last_i && ADDR_W'(wr_addr_o + 1'b1) % ADDR_W'(PAGE_BYTES / 4) == '0) |-> stop_o);

  assert_retry_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (start_i && valid_i && free_i == '0) |-> (devsel_o && stop_o && !trdy_o && !wr_o));

  assert_release_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_i && devsel_o && (stop_o || last_i)) |=> (!devsel_o || start_i));
endmodule

// File: tb/pw_accept_ctl_tb.sv
`timescale 1ns/1ps
module pw_accept_ctl_tb;
  logic        clk = 0, rst_n = 0;
  logic        start_i = 0, valid_i = 0, last_i = 0, mwi_i = 0, line_disc_en_i = 0;
  logic [15:0] addr_i = 0;
  logic [7:0]  cls_i = 0;
  logic [5:0]  free_i = 0;
  logic        devsel_o, trdy_o, stop_o, wr_o;
  logic [15:0] wr_addr_o;
  int n_chk = 0, n_bad = 0;

  always #5 clk = ~clk;

  pw_accept_ctl #(.ADDR_W(16), .FREE_W(6), .PAGE_BYTES(256)) u_dut (.*);

  task automatic chk(string req, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic idle_chk(string req);
    @(negedge clk);
    start_i = 0; valid_i = 0; last_i = 0;
    #1;
    chk(req, "devsel idle", devsel_o, 0);
    chk(req, "stop idle", stop_o, 0);
    chk(req, "trdy idle", trdy_o, 0);
  endtask

  task automatic run_burst(string req, logic [15:0] a, bit mwi, bit ctl, logic [7:0] cls,
                           int len, int f0, int exp_stop, bit gap);
    int f = f0;
    cls_i = cls; line_disc_en_i = ctl;
    for (int i = 0; i < len; i++) begin
      @(negedge clk);
      start_i = (i == 0); valid_i = 1; last_i = (i == len - 1);
      mwi_i = mwi; addr_i = a; free_i = 6'(f);
      #1;
      chk(req, "devsel", devsel_o, 1);
      chk(req, "trdy", trdy_o, 1);
      chk(req, "wr", wr_o, 1);
      chk(req, "addr", wr_addr_o, a + i);
      chk(req, "stop", stop_o, (i == exp_stop));
      if (i == exp_stop || i == len - 1) break;
      f--;
    end
    if (gap) idle_chk(req);
  endtask

  task automatic retry(string req, logic [15:0] a);
    @(negedge clk);
    start_i = 1; valid_i = 1; last_i = 0; addr_i = a; free_i = 0;
    #1;
    chk(req, "retry devsel", devsel_o, 1);
    chk(req, "retry stop", stop_o, 1);
    chk(req, "retry trdy", trdy_o, 0);
    chk(req, "retry wr", wr_o, 0);
    idle_chk(req);
  endtask

  task automatic mid_empty();
    @(negedge clk);
    start_i = 1; valid_i = 1; last_i = 0; mwi_i = 0; addr_i = 16'h200; free_i = 5;
    cls_i = 0; line_disc_en_i = 0;
    #1;
    chk("R11", "first trdy", trdy_o, 1);
    @(negedge clk);
    start_i = 0; free_i = 0;
    #1;
    chk("R11", "stop", stop_o, 1);
    chk("R11", "trdy", trdy_o, 0);
    chk("R11", "wr", wr_o, 0);
    idle_chk("R11");
  endtask

  initial begin
    #2000000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #1;
    chk("R10", "reset devsel", devsel_o, 0);
    chk("R10", "reset trdy", trdy_o, 0);
    chk("R10", "reset stop", stop_o, 0);
    chk("R10", "reset wr", wr_o, 0);
    #24 rst_n = 1;
    run_burst("R1",  16'h010, 0, 0, 8'd8,  4, 20, -1, 1);
    run_burst("R3",  16'h003, 1, 0, 8'd8, 10, 30,  4, 1);
    run_burst("R4",  16'h021, 0, 1, 8'd4, 10, 30,  2, 1);
    run_burst("R5",  16'h021, 0, 0, 8'd4, 10, 20, -1, 1);
    run_burst("R6",  16'h03C, 1, 1, 8'd3, 10, 30,  3, 1);
    run_burst("R6",  16'h005, 1, 1, 8'd0,  8, 30, -1, 1);
    run_burst("R6",  16'h01E, 1, 1, 8'd32, 6, 30, -1, 1);
    run_burst("R7",  16'h07D, 0, 0, 8'd16, 8, 30,  2, 1);
    run_burst("R2",  16'h100, 0, 0, 8'd0, 10,  3,  2, 1);
    run_burst("R10", 16'h110, 0, 0, 8'd0,  3,  3, -1, 1);
    retry("R8", 16'h120);
    run_burst("R9",  16'h300, 0, 0, 8'd0,  2, 10, -1, 0);
    run_burst("R9",  16'h310, 0, 0, 8'd0,  3, 10, -1, 0);
    retry("R9", 16'h320);
    mid_empty();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule